// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Flag Timing

This block moves 36-bit words in one direction, from a write port on one free-running clock to a read port on a second clock. The two clocks may be unrelated or the same net. The store holds 1024 words, and a read and a write on the same edge are both accepted. The write and read pointers cross between domains as Gray codes through two-flop synchronizers. Each flag is computed in the domain of the clock that owns it.

A full reset samples a timing-mode select and two threshold offsets. Each is held until the next full reset. In standard mode a word reaches `rdData` only when a read fetches it into the output register. In fall-through mode the head word is loaded into the output register without a read, and a read retires it. A partial reset empties the FIFO but keeps the captured mode and offsets. Almost-empty works on the read clock and almost-full on the write clock, and both compare a fill level against the captured offsets.

Top module: `cdc_fifo_top`

## Requirements
- R1: Words leave the read port in the order they were accepted at the write port, with all 36 bits intact, and 1024 words can be stored.
- R2: Standard mode (`fwftSel`=0 at full reset): `outFlag` is high when the store holds a word. It rises at the 2nd read-clock edge after the write edge. A word reaches `rdData` only at the read-clock edge that samples `rdEn` high, and `rdData` holds otherwise.
- R3: Fall-through mode (`fwftSel`=1 at full reset): `outFlag` means the output register holds a valid word. The first word written to an empty FIFO appears on `rdData`, with `outFlag` high, at the 3rd read-clock edge after the write edge, with no read. A read edge replaces it with the next word.
- R4: `inFlag` is low while 1024 words are counted on the write side. A write attempted while `inFlag` is low is ignored.
- R5: In standard mode, a read while `outFlag` is low is ignored. `rdData` and the read position do not change.
- R6: `almostFull` is high exactly when the write-side fill level is at least 1024 minus the captured `afOffset`. The write-side level is accepted writes minus the reads seen through the synchronizer.
- R7: `almostEmpty` is high exactly when the read-side fill level is at or below the captured `aeOffset`. The read-side level is the synchronized writes minus reads, plus one for a valid fall-through output word.
- R8: `fwftSel`, `aeOffset` and `afOffset` are captured only while `fullRstN` is low. Later changes on these inputs have no effect.
- R9: A partial reset (`partRstN` low) empties the FIFO and clears `rdData` to 0. It keeps the mode and offsets captured at the last full reset.
- R10: A write and a read on the same edge are both accepted, and the fill level is unchanged.
- R11: The pointer copy sent across domains changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wClk | input | 1 | Write-side clock |
| rClk | input | 1 | Read-side clock |
| fullRstN | input | 1 | Active-low full reset; clears data and captures configuration |
| partRstN | input | 1 | Active-low partial reset; clears data only |
| fwftSel | input | 1 | Mode select sampled in full reset: 0 standard, 1 fall-through |
| aeOffset | input | 10 | Almost-empty threshold, sampled in full reset |
| afOffset | input | 10 | Almost-full threshold, sampled in full reset |
| wrEn | input | 1 | Write request |
| wrData | input | 36 | Write data |
| rdEn | input | 1 | Read request |
| rdData | output | 36 | Output register |
| inFlag | output | 1 | High when a write will be accepted (full flag, active low) |
| outFlag | output | 1 | Standard: store not empty; fall-through: output word valid |
| almostEmpty | output | 1 | Read-clock almost-empty flag |
| almostFull | output | 1 | Write-clock almost-full flag |

## Verification
With both clocks tied together, a write edge shows on the read side after two synchronizer edges. Standard `outFlag` and `almostEmpty` therefore change after the 2nd edge, and the fall-through word appears after the 3rd. A read shows on `inFlag` and `almostFull` after two write edges. A standard read puts data on `rdData` after the single edge that samples `rdEn`. The bench drives inputs on falling edges. It samples at the falling edge that follows the edge where each result is due, and it waits three edges before it compares the flags in a fill sweep. A final run uses unrelated clocks and checks only the order and content of the data.

// File: rtl/cdc_fifo_pkg.sv
package cdc_fifo_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrStb;    // store wrData at write address (write clock)
    logic loadStb;  // load output register from read address (read clock)
  } memStrobes_t;
endpackage

// File: rtl/cdc_fifo_gsync.sv
module cdc_fifo_gsync #(
  parameter int WIDTH  = 11,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/cdc_fifo_ctrl.sv
module cdc_fifo_ctrl
  import cdc_fifo_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wClk,
  input  logic              rClk,
  input  logic              fullRstN,
  input  logic              rstN,
  input  logic              fwftSel,
  input  logic [ADDR_W-1:0] aeOffset,
  input  logic [ADDR_W-1:0] afOffset,
  input  logic              wrEn,
  input  logic              rdEn,
  output memStrobes_t       strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              inFlag,
  output logic              outFlag,
  output logic              almostEmpty,
  output logic              almostFull
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1) << ADDR_W;

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [ADDR_W-1:0] afOffR;
  logic [PW-1:0]     wBin, wGray, rGraySync, rBinSync, wLevel, wBinNext;
  logic              full;

  always_ff @(posedge wClk) begin
    if (!fullRstN) afOffR <= afOffset;
  end

  cdc_fifo_gsync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_rSync (
    .clk(wClk), .rstN(rstN), .din(rGray), .dout(rGraySync)
  );

  assign rBinSync    = grayToBin(rGraySync);
  assign wLevel      = wBin - rBinSync;
  assign full        = (wLevel == DEPTH);
  assign strb.wrStb  = wrEn & ~full;
  assign wBinNext    = wBin + PW'(1);

  always_ff @(posedge wClk or negedge rstN) begin
    if (!rstN) begin
      wBin  <= '0;
      wGray <= '0;
    end else if (strb.wrStb) begin
      wBin  <= wBinNext;
      wGray <= wBinNext ^ (wBinNext >> 1);
    end
  end

  assign wrAddr     = wBin[ADDR_W-1:0];
  assign inFlag     = ~full;
  assign almostFull = (wLevel >= (DEPTH - PW'(afOffR)));

  // ---------------- read domain ----------------
  logic              fwftR;
  logic [ADDR_W-1:0] aeOffR;
  logic [PW-1:0]     rBin, rGray, wGraySync, wBinSync, memLevel, rBinNext;
  logic [PW:0]       rdLevel;
  logic              memEmpty, outValid;

  always_ff @(posedge rClk) begin
    if (!fullRstN) begin
      fwftR  <= fwftSel;
      aeOffR <= aeOffset;
    end
  end

  cdc_fifo_gsync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_wSync (
    .clk(rClk), .rstN(rstN), .din(wGray), .dout(wGraySync)
  );

  assign wBinSync     = grayToBin(wGraySync);
  assign memLevel     = wBinSync - rBin;
  assign memEmpty     = (memLevel == '0);
  assign strb.loadStb = ~memEmpty & (fwftR ? (~outValid | rdEn) : rdEn);
  assign rBinNext     = rBin + PW'(1);

  always_ff @(posedge rClk or negedge rstN) begin
    if (!rstN) begin
      rBin     <= '0;
      rGray    <= '0;
      outValid <= 1'b0;
    end else begin
      if (strb.loadStb) begin
        rBin  <= rBinNext;
        rGray <= rBinNext ^ (rBinNext >> 1);
      end
      if (!fwftR)            outValid <= 1'b0;
      else if (strb.loadStb) outValid <= 1'b1;
      else if (rdEn)         outValid <= 1'b0;
    end
  end

  assign rdAddr      = rBin[ADDR_W-1:0];
  assign outFlag     = fwftR ? outValid : ~memEmpty;
  assign rdLevel     = {1'b0, memLevel} + (PW+1)'(fwftR & outValid);
  assign almostEmpty = (rdLevel <= (PW+1)'(aeOffR));

  // ---------------- assertions ----------------
  a_r4_no_write_when_full: assert property (@(posedge wClk) disable iff (!rstN)
    (full && wrEn) |=> $stable(wBin));
  a_r5_no_read_when_empty: assert property (@(posedge rClk) disable iff (!rstN)
    memEmpty |=> $stable(rBin));
  a_r1_level_bound: assert property (@(posedge wClk) disable iff (!rstN)
    wLevel <= DEPTH);
  a_r6_full_is_almost_full: assert property (@(posedge wClk) disable iff (!rstN)
    full |-> almostFull);
  a_r11_wgray_step: assert property (@(posedge wClk) disable iff (!rstN)
    $onehot0(wGray ^ $past(wGray)));
  a_r11_rgray_step: assert property (@(posedge rClk) disable iff (!rstN)
    $onehot0(rGray ^ $past(rGray)));
  a_r3_head_held: assert property (@(posedge rClk) disable iff (!rstN)
    (fwftR && outValid && !rdEn) |=> outValid);
endmodule

// File: rtl/cdc_fifo_dpath.sv
module cdc_fifo_dpath
  import cdc_fifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 10
) (
  input  logic              wClk,
  input  logic              rClk,
  input  logic              rstN,
  input  memStrobes_t       strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wClk) begin
    if (strb.wrStb) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rClk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strb.loadStb) rdData <= mem[rdAddr];
  end

  a_r2_out_reg_holds: assert property (@(posedge rClk) disable iff (!rstN)
    !strb.loadStb |=> $stable(rdData));
endmodule

// File: rtl/cdc_fifo_top.sv
module cdc_fifo_top
  import cdc_fifo_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wClk,
  input  logic              rClk,
  input  logic              fullRstN,
  input  logic              partRstN,
  input  logic              fwftSel,
  input  logic [ADDR_W-1:0] aeOffset,
  input  logic [ADDR_W-1:0] afOffset,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              inFlag,
  output logic              outFlag,
  output logic              almostEmpty,
  output logic              almostFull
);
  logic              rstN;
  memStrobes_t       strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  assign rstN = fullRstN & partRstN;

  cdc_fifo_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wClk(wClk), .rClk(rClk), .fullRstN(fullRstN), .rstN(rstN),
    .fwftSel(fwftSel), .aeOffset(aeOffset), .afOffset(afOffset),
    .wrEn(wrEn), .rdEn(rdEn), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inFlag(inFlag), .outFlag(outFlag),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  cdc_fifo_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .wClk(wClk), .rClk(rClk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/cdc_fifo_top_tb.sv
`timescale 1ns/1ps
module cdc_fifo_top_tb;
  localparam int DW = 36;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic wClk = 0, altClk = 0, asyncMode = 0;
  logic rClk;
  logic fullRstN = 0, partRstN = 1, fwftSel = 0, wrEn = 0, rdEn = 0;
  logic [AW-1:0] aeOffset = 8, afOffset = 16;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic inFlag, outFlag, almostEmpty, almostFull;
  int nChecks = 0, nFails = 0;

  always #10 wClk = ~wClk;     // 50 MHz
  always #17 altClk = ~altClk; // unrelated read clock
  assign rClk = asyncMode ? altClk : wClk;

  cdc_fifo_top u_dut (
    .wClk(wClk), .rClk(rClk), .fullRstN(fullRstN), .partRstN(partRstN),
    .fwftSel(fwftSel), .aeOffset(aeOffset), .afOffset(afOffset),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .inFlag(inFlag), .outFlag(outFlag),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  function automatic logic [DW-1:0] val(input int i);
    return 36'h5_A000_0000 ^ (DW'(i) * 36'd40503);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge wClk);
  endtask

  task automatic pulseReset(input bit full);
    @(negedge wClk);
    if (full) fullRstN = 0; else partRstN = 0;
    tick(3);
    fullRstN = 1; partRstN = 1;
    tick(2);
  endtask

  task automatic writeWord(input logic [DW-1:0] v);
    wrEn = 1; wrData = v; tick(1); wrEn = 0;
  endtask

  task automatic readWord();
    rdEn = 1; tick(1); rdEn = 0;
  endtask

  initial begin
    #4_000_000;
    nFails++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    // ---- full reset, standard mode, ae=8 af=16 ----
    fwftSel = 0; aeOffset = 8; afOffset = 16;
    pulseReset(1);
    chk("reset outFlag", outFlag, 0);
    chk("reset inFlag", inFlag, 1);
    chk("reset almostEmpty", almostEmpty, 1);
    chk("reset almostFull", almostFull, 0);
    chk("reset rdData", rdData, 0);

    // ---- fill sweep: R2 timing, R4, R6, R7 ----
    for (int n = 1; n <= DEPTH; n++) begin
      writeWord(val(n - 1));
      if (n == 1) begin
        chk("R2 outFlag edge0", outFlag, 0);
        tick(1); chk("R2 outFlag edge1", outFlag, 0);
        tick(1); chk("R2 outFlag edge2", outFlag, 1);
        chk("R2 no fall-through", rdData, 0);
      end else tick(2);
      chk("R7 ae fill", almostEmpty, (n <= 8));
      chk("R6 af fill", almostFull, (n >= DEPTH - 16));
      chk("R4 inFlag fill", inFlag, (n < DEPTH));
    end
    writeWord(36'hF_FFFF_FFFF); tick(2);
    chk("R4 full stays", inFlag, 0);

    // ---- drain sweep: R1 order, R2 read latency, flags ----
    for (int k = 0; k < DEPTH; k++) begin
      readWord();
      chk("R1 R2 data", rdData, val(k));
      tick(2);
      chk("R7 ae drain", almostEmpty, ((DEPTH - 1 - k) <= 8));
      chk("R6 af drain", almostFull, ((DEPTH - 1 - k) >= DEPTH - 16));
      chk("R2 outFlag drain", outFlag, ((DEPTH - 1 - k) > 0));
      chk("R4 inFlag drain", inFlag, 1);
    end

    // ---- R5: read while empty ----
    readWord();
    chk("R5 rdData held", rdData, val(DEPTH - 1));
    tick(2);
    chk("R5 still empty", outFlag, 0);
    writeWord(val(7)); tick(3);
    chk("R2 held before read", rdData, val(DEPTH - 1));
    readWord();
    chk("R5 pointer unchanged", rdData, val(7));

    // ---- R10: simultaneous read and write ----
    for (int i = 0; i < 4; i++) writeWord(val(100 + i));
    tick(2);
    for (int k = 0; k < 20; k++) begin
      wrEn = 1; wrData = val(104 + k); rdEn = 1;
      tick(1);
      chk("R10 data", rdData, val(100 + k));
    end
    wrEn = 0; rdEn = 0; tick(3);
    chk("R10 level ae", almostEmpty, 1);
    chk("R10 not empty", outFlag, 1);
    for (int k = 0; k < 4; k++) begin
      readWord();
      chk("R10 tail", rdData, val(120 + k));
    end
    tick(2);
    chk("R10 drained", outFlag, 0);

    // ---- R9: partial reset keeps mode and offsets ----
    for (int i = 0; i < 5; i++) writeWord(val(200 + i));
    tick(2);
    fwftSel = 1; aeOffset = 2; afOffset = 500;
    pulseReset(0);
    chk("R9 emptied", outFlag, 0);
    chk("R9 rdData cleared", rdData, 0);
    chk("R9 ae after", almostEmpty, 1);
    chk("R9 inFlag", inFlag, 1);
    for (int n = 1; n <= 9; n++) begin
      writeWord(val(300 + n)); tick(2);
      if (n == 1) begin
        tick(1);
        chk("R9 mode kept (no fall-through)", rdData, 0);
      end
      chk("R9 ae offset kept", almostEmpty, (n <= 8));
    end
    for (int n = 1; n <= 9; n++) begin
      readWord();
      chk("R9 R1 data", rdData, val(300 + n));
    end

    // ---- R8 / R3: full reset into fall-through ----
    fwftSel = 1; aeOffset = 4; afOffset = 64;
    pulseReset(1);
    fwftSel = 0; aeOffset = 100; afOffset = 1;
    chk("R8 inFlag", inFlag, 1);
    chk("R8 almostFull", almostFull, 0);
    writeWord(val(500));
    chk("R3 edge0", outFlag, 0);
    tick(1); chk("R3 edge1", outFlag, 0);
    tick(1); chk("R3 edge2", outFlag, 0);
    tick(1); chk("R3 edge3 flag", outFlag, 1);
    chk("R3 edge3 data", rdData, val(500));
    for (int i = 1; i < 6; i++) writeWord(val(500 + i));
    tick(3);
    chk("R8 R7 ae level6", almostEmpty, 0);
    for (int k = 1; k <= 6; k++) begin
      readWord();
      if (k < 6) chk("R3 next word", rdData, val(500 + k));
      tick(2);
      chk("R8 R7 ae fwft", almostEmpty, ((6 - k) <= 4));
      chk("R3 outFlag fwft", outFlag, ((6 - k) > 0));
    end

    // ---- R1 / R3 with unrelated clocks ----
    asyncMode = 1;
    fwftSel = 1; aeOffset = 4; afOffset = 64;
    @(negedge wClk); fullRstN = 0;
    repeat (4) @(negedge altClk);
    @(negedge wClk); fullRstN = 1;
    tick(2);
    fork
      begin
        int i = 0;
        while (i < 300) begin
          @(negedge wClk);
          if (inFlag) begin wrEn = 1; wrData = val(1000 + i); i++; end
          else wrEn = 0;
        end
        @(negedge wClk); wrEn = 0;
      end
      begin
        int j = 0, cyc = 0;
        while (j < 300) begin
          @(negedge rClk);
          cyc++;
          if (outFlag && (cyc % 3 != 0)) begin
            chk("R1 async order", rdData, val(1000 + j));
            rdEn = 1; j++;
          end else rdEn = 0;
        end
        @(negedge rClk); rdEn = 0;
      end
    join
    repeat (4) @(negedge rClk);
    chk("R1 async drained", outFlag, 0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule